// File: doc/BRIEF.md
# Block Transfer Sequencer

This block steps a simple 32-bit core through one load-multiple or store-multiple instruction. When `start` is pulsed it takes a 16-bit register mask, the base register's number and value, and the mode flags: increment or decrement, address before or after, base update, and condition pass. It then drives one memory access per cycle, lowest-numbered register at the lowest address. For stores it names the register to read. For loads it names the register to write. It also writes the updated base back through the same register write port.

The base update always lands in the first transfer cycle, which is the second cycle of the instruction. This fixes what happens when the base register is also in the mask. A store of the base as its first transfer sends the old value, and a store of the base later in the sequence sends the updated value. A load of the base always leaves the loaded word in the register. Memory is a single-cycle port: a read issued in one cycle returns its data in the next cycle, and the sequencer writes that data to the register file in that same next cycle.

Top module: `lsm_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `mem_req`, `rf_we`, `done` and `pc_redirect` are low.
- R2: Transfers run one per cycle in ascending register order. Each access address is 4 more than the previous one, so the lowest register uses the lowest address.
- R3: The first address depends on the mode, where N is the number of set mask bits. Increment-after starts at base. Increment-before starts at base+4. Decrement-before starts at base-4N. Decrement-after starts at base-4N+4.
- R4: With `wb_en` set, the base register is written in the first transfer cycle. The value written is base+4N when incrementing and base-4N when decrementing. With `wb_en` clear, the base register is not written.
- R5: A store that includes the base sends the original base when the base is the lowest set bit. When the base comes later in the sequence and `wb_en` is set, the store sends the updated base.
- R6: A load that includes the base leaves the loaded word in the base register, even when `wb_en` is set.
- R7: With `cond_ok` low, the block makes no memory access and no register write, and `done` is high in the cycle after the start edge.
- R8: An empty mask makes no memory access, leaves the base unchanged, and raises `done` in the cycle after the start edge.
- R9: A load whose mask includes register 15 pulses `pc_redirect` in the cycle that register 15 is written. That cycle is the `done` cycle.
- R10: For N greater than 0 with `cond_ok` high, `done` is high for exactly one cycle: the cycle after the (N+2)th rising edge counted from the start edge inclusive. No memory request occurs in that cycle.
- R11: A loaded word is written to its register in the cycle after its read request. The data is taken from `mem_rdata` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (ignored while busy) |
| is_load | input | 1 | 1 = load multiple, 0 = store multiple |
| reg_list | input | 16 | Register mask, bit i selects register i |
| base_idx | input | 4 | Number of the base register |
| base_val | input | 32 | Current value of the base register |
| up | input | 1 | 1 = increment, 0 = decrement |
| pre | input | 1 | 1 = step before access, 0 = after |
| wb_en | input | 1 | Write the updated base back |
| cond_ok | input | 1 | Condition passed; 0 suppresses everything |
| rf_rd_data | input | 32 | Register file read data for `rf_rd_idx` |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read |
| busy | output | 1 | Instruction in progress |
| rf_rd_idx | output | 4 | Register being stored |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| done | output | 1 | Instruction finished (one cycle) |
| pc_redirect | output | 1 | Program counter is being loaded |

## Verification
In the first transfer cycle of a store, the base update and a memory write happen at the same time. When the base is the lowest set bit, that same-cycle write must still read the old base. The bench places the base first in one mask and second in another, with `wb_en` set, and compares the stored words with values it computes itself. For loads, the base update in the first transfer cycle and the later load into the same register share the one write port. A mask that names only the base, and one that includes it among other registers, check that the final register value is the loaded word.

// File: rtl/lsm_seq.sv
module lsm_seq #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_load,
  input  logic [NREG-1:0] reg_list,
  input  logic [RW-1:0]   base_idx,
  input  logic [AW-1:0]   base_val,
  input  logic            up,
  input  logic            pre,
  input  logic            wb_en,
  input  logic            cond_ok,
  input  logic [DW-1:0]   rf_rd_data,
  input  logic [DW-1:0]   mem_rdata,
  output logic            busy,
  output logic [RW-1:0]   rf_rd_idx,
  output logic            rf_we,
  output logic [RW-1:0]   rf_wr_idx,
  output logic [DW-1:0]   rf_wr_data,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            done,
  output logic            pc_redirect
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_XFER, S_FIN} st_t;

  st_t            st;
  logic [NREG-1:0] rem;
  logic [AW-1:0]  addr_q, wbval_q;
  logic [RW-1:0]  bidx_q, ld_idx_q, cur;
  logic           load_q, wb_q, first_q, ld_pend_q;

  logic [CW-1:0]  cnt;
  logic [AW-1:0]  off, start_addr, new_base;
  logic [NREG-1:0] rem_next;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(reg_list[i]);
  end

  always_comb begin
    cur = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rem[i]) cur = RW'(i);
  end

  assign off        = AW'(cnt) << 2;
  assign new_base   = up ? base_val + off : base_val - off;
  assign start_addr = up ? (pre ? base_val + AW'(4) : base_val)
                         : (pre ? base_val - off : base_val - off + AW'(4));
  assign rem_next   = rem & ~(NREG'(1) << cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rem       <= '0;
      addr_q    <= '0;
      wbval_q   <= '0;
      bidx_q    <= '0;
      ld_idx_q  <= '0;
      load_q    <= 1'b0;
      wb_q      <= 1'b0;
      first_q   <= 1'b0;
      ld_pend_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          ld_pend_q <= 1'b0;
          if (start) begin
            if (cond_ok && |reg_list) begin
              st      <= S_SETUP;
              rem     <= reg_list;
              addr_q  <= start_addr;
              wbval_q <= new_base;
              bidx_q  <= base_idx;
              load_q  <= is_load;
              wb_q    <= wb_en;
            end else begin
              st <= S_FIN;
            end
          end
        end
        S_SETUP: begin
          st        <= S_XFER;
          first_q   <= 1'b1;
          ld_pend_q <= 1'b0;
        end
        S_XFER: begin
          addr_q    <= addr_q + AW'(4);
          rem       <= rem_next;
          first_q   <= 1'b0;
          ld_pend_q <= load_q;
          ld_idx_q  <= cur;
          if (rem_next == '0) st <= S_FIN;
        end
        default: begin
          st        <= S_IDLE;
          ld_pend_q <= 1'b0;
        end
      endcase
    end
  end

  logic wb_now;
  assign wb_now      = (st == S_XFER) && first_q && wb_q;

  assign busy        = (st != S_IDLE);
  assign mem_req     = (st == S_XFER);
  assign mem_we      = (st == S_XFER) && !load_q;
  assign mem_addr    = addr_q;
  assign mem_wdata   = rf_rd_data;
  assign rf_rd_idx   = cur;
  assign rf_we       = wb_now || ld_pend_q;
  assign rf_wr_idx   = wb_now ? bidx_q : ld_idx_q;
  assign rf_wr_data  = wb_now ? DW'(wbval_q) : mem_rdata;
  assign done        = (st == S_FIN);
  assign pc_redirect = ld_pend_q && (ld_idx_q == RW'(NREG - 1));

endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        rf_we,
  input logic        done,
  input logic        pc_redirect
);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + 32'd4));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  // R4
  wb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && mem_we) |-> !$past(mem_req));

  // R9
  redirect_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_redirect |-> done);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !rf_we && !done));

endmodule

bind lsm_seq lsm_seq_chk u_lsm_seq_chk (.*);

// File: tb/test_lsm_seq.sv
module test_lsm_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, is_load = 1'b0, up = 1'b0, pre = 1'b0, wb_en = 1'b0, cond_ok = 1'b0;
  logic [15:0] reg_list = '0;
  logic [3:0]  base_idx = '0;
  logic [31:0] base_val, rf_rd_data, rf_wr_data, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        busy, rf_we, mem_req, mem_we, done, pc_redirect;
  logic [3:0]  rf_rd_idx, rf_wr_idx;

  logic [31:0] regs [16];
  logic [31:0] mem  [64];
  logic [31:0] xregs[16];
  logic [31:0] xmem [64];

  int errors = 0, checks = 0, cyc = 0, redirects = 0;

  always #4 clk = ~clk;

  assign base_val   = regs[base_idx];
  assign rf_rd_data = regs[rf_rd_idx];

  lsm_seq i_lsm_seq (.*);

  always @(posedge clk) begin
    if (rf_we) regs[rf_wr_idx] <= rf_wr_data;
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:2]];
    end
    if (pc_redirect) redirects <= redirects + 1;
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R10 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // fields: [31] load [30] up [29] pre [28] wb [27] cond [19:16] base [15:0] mask
  localparam logic [31:0] VEC [13] = '{
    32'h5802_00F0, 32'h6804_0311, 32'h380D_A00C, 32'h1805_0006,
    32'h5803_0088, 32'h5807_0088, 32'hD801_00E0, 32'hB806_0050,
    32'hE800_8006, 32'hD002_00FF, 32'h5803_0000, 32'h9809_0200,
    32'h3800_FFFF
  };

  task automatic run_vec(input int v, input logic [31:0] w);
    logic        ld, u, p, wb, c;
    logic [3:0]  b;
    logic [15:0] m;
    logic [31:0] old, nb, sa, a;
    int n, k, lat, exp_lat, exp_red;
    bit ok;
    ld = w[31]; u = w[30]; p = w[29]; wb = w[28]; c = w[27];
    b = w[19:16]; m = w[15:0];
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      regs[i] = 32'hA000_0000 | (32'(v) << 8) | 32'(i);
      xregs[i] = regs[i];
    end
    regs[b] = 32'h80; xregs[b] = 32'h80;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'h5000_0000 | (32'(v) << 8) | 32'(i);
      xmem[i] = mem[i];
    end
    n = $countones(m);
    old = 32'h80;
    nb = u ? old + 32'(4 * n) : old - 32'(4 * n);
    sa = u ? (p ? old + 4 : old) : (p ? old - 32'(4 * n) : old - 32'(4 * n) + 4);
    if (c && n > 0) begin
      if (ld && wb) xregs[b] = nb;
      k = 0;
      for (int r = 0; r < 16; r++) if (m[r]) begin
        a = sa + 32'(4 * k);
        if (ld) xregs[r] = xmem[a[7:2]];
        else    xmem[a[7:2]] = (r == int'(b)) ? ((k == 0 || !wb) ? old : nb) : xregs[r];
        k++;
      end
      if (!ld && wb) xregs[b] = nb;
    end
    exp_lat = (c && n > 0) ? n + 2 : 1;
    exp_red = (ld && c && n > 0 && m[15]) ? 1 : 0;
    redirects = 0;
    is_load = ld; up = u; pre = p; wb_en = wb; cond_ok = c; base_idx = b; reg_list = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    // R10 latency; R7 R8 for suppressed or empty
    check(lat == exp_lat, $sformatf("R10/R7/R8 latency vec %0d", v), 32'(lat), 32'(exp_lat));
    @(negedge clk);
    ok = 1'b1;
    for (int i = 0; i < 16; i++) if (regs[i] !== xregs[i]) begin
      ok = 1'b0;
      check(1'b0, $sformatf("R4/R6/R9/R11 reg %0d vec %0d", i, v), regs[i], xregs[i]);
    end
    if (ok) check(1'b1, "R4", 0, 0);
    ok = 1'b1;
    for (int i = 0; i < 64; i++) if (mem[i] !== xmem[i]) begin
      ok = 1'b0;
      check(1'b0, $sformatf("R2/R3/R5 mem word %0d vec %0d", i, v), mem[i], xmem[i]);
    end
    if (ok) check(1'b1, "R2", 0, 0);
    // R9
    check(redirects == exp_red, $sformatf("R9 redirect count vec %0d", v), 32'(redirects), 32'(exp_red));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !mem_req && !rf_we && !done && !pc_redirect, "R1 reset outputs",
          {27'd0, busy, mem_req, rf_we, done, pc_redirect}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req && !rf_we && !done, "R1 idle after reset",
          {28'd0, busy, mem_req, rf_we, done}, 32'd0);
    for (int v = 0; v < 13; v++) run_vec(v, VEC[v]);
    // R5 directed: base first stores old, base second stores new
    run_vec(20, 32'h5803_0088);
    check(mem[32'h80 >> 2] === 32'h80, "R5 base first keeps old", mem[32'h80 >> 2], 32'h80);
    run_vec(21, 32'h5807_0088);
    check(mem[32'h84 >> 2] === 32'h88, "R5 base second stores new", mem[32'h84 >> 2], 32'h88);
    // R6 directed: loaded word wins over writeback
    run_vec(22, 32'hD806_0040);
    check(regs[6] === (32'h5000_0000 | (32'd22 << 8) | 32'd32), "R6 load overwrites base",
          regs[6], 32'h5000_0000 | (32'd22 << 8) | 32'd32);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule